// File: doc/BRIEF.md
# Eight-Bit Rollover Pulse-Width Modulator

This block produces one pulse-width modulated output from an eight-bit up-counter. The counter is stepped by a prescaled tick. In fast mode there is one step every two system clocks. In slow mode there is one step every 2×(N+1) system clocks, where N comes from a divider input. Each time the counter wraps from its top value back to zero, the output is driven high. The output is driven low when the counter value reaches the active duty value. The output is therefore high for `duty` counter steps out of every 256.

Software writes a new duty value through a one-cycle write strobe. The value is held in a staging register and copied into the active compare register only when the counter wraps. A write in the middle of a period therefore never shortens or extends the pulse already in progress. While the enable input is low, the counter and the prescaler are held at zero and the output stays low. The active duty register follows the staging register during this time, so the first pulse after enabling uses the most recent write.

Top module: `pwm8_rollover`

## Requirements
- R1: During and right after reset the output `pwm_out` is low, and the counter and prescaler start from zero.
- R2: With `slow_mode` = 0 the counter advances once every 2 system clocks, so one full output period lasts 512 clocks.
- R3: With `slow_mode` = 1 the counter advances once every 2×(`slow_div`+1) system clocks, and the period is 256 times that.
- R4: The output goes high on the step where the counter wraps from 0xFF to 0x00, provided the duty value loaded at that wrap is not zero.
- R5: The output goes low on the step where the counter becomes equal to the active duty value, so the high time is duty × step length in clocks.
- R6: A duty value of 0x00 keeps the output low for the whole period.
- R7: A duty value of 0xFF gives the longest pulse, high for 255 of the 256 steps.
- R8: A value written with `duty_wr` goes to a staging register and becomes active only at the next wrap. The pulse in progress keeps its old length.
- R9: While `en` is low the output is low and the counter is held at 0x00. After `en` rises, the first high edge comes exactly 256 steps later.
- R10: While `en` is low the active duty tracks the staging register, so a value written while disabled sets the first pulse after enabling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds the counter at zero and the output low |
| slow_mode | input | 1 | 0 = step every 2 clocks, 1 = step every 2×(slow_div+1) clocks |
| slow_div | input | DIV_W (8) | Divider setting used in slow mode |
| duty_wr | input | 1 | One-cycle strobe that writes `duty_wdata` into the staging register |
| duty_wdata | input | CNT_W (8) | New duty value |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The generator runs in fast mode with duty values 0x01, 0x40, 0x80 and 0xFF. Measuring both the high time and the full period in clocks separates a wrong compare point from a wrong step rate. Duty 0x00 is watched over more than a full period to show that no rising edge appears. A slow-mode run with divider 3 confirms that the prescaler scales both the high time and the period by the same factor. A write issued just after a rising edge shows that the pulse in progress keeps its old length. Finally, the delay from enable to the first rising edge, with a duty value written while disabled, shows that the counter really restarts from zero and that the active duty tracks the staging register.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;

   typedef enum logic {
      STEP_FAST = 1'b0,
      STEP_SLOW = 1'b1
   } step_mode_e;

   // Divider style: linear gives 2*(div+1), exponential gives 2<<div
   localparam int DIV_LINEAR = 0;
   localparam int DIV_EXP    = 1;

   function automatic int pre_width(input int div_w, input int style);
      if (style == DIV_EXP) return (1 << div_w) + 2;
      return div_w + 2;
   endfunction

endpackage

// File: rtl/pwm8_tick_gen.sv
module pwm8_tick_gen
   import pwm8_pkg::*;
#(
   parameter int DIV_W     = 8,
   parameter int DIV_STYLE = DIV_LINEAR
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  step_mode_e       mode,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   localparam int PRE_W = pre_width(DIV_W, DIV_STYLE);

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] slow_lim;
   logic [PRE_W-1:0] limit;

   generate
      if (DIV_STYLE == DIV_EXP) begin : g_exp
         always_comb slow_lim = PRE_W'(2) << div;
      end else begin : g_lin
         always_comb slow_lim = (PRE_W'(div) + PRE_W'(1)) << 1;
      end
   endgenerate

   always_comb begin
      limit = (mode == STEP_SLOW) ? slow_lim : PRE_W'(2);
      // >= keeps the count bounded if the mode is changed mid-count
      tick  = run && (pre_q >= (limit - PRE_W'(1)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pre_q <= '0;
      else if (!run)   pre_q <= '0;
      else if (tick)   pre_q <= '0;
      else             pre_q <= pre_q + PRE_W'(1);
   end

endmodule

// File: rtl/pwm8_wrap_counter.sv
module pwm8_wrap_counter #(
   parameter int CNT_W = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cnt_next,
   output logic             wrap
);

   localparam logic [CNT_W-1:0] TOP = '1;

   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      cnt_next = cnt_q + CNT_W'(1);
      wrap     = tick && (cnt_q == TOP);
      cnt      = cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (!run)  cnt_q <= '0;
      else if (tick)  cnt_q <= cnt_next;
   end

endmodule

// File: rtl/pwm8_duty_bank.sv
module pwm8_duty_bank #(
   parameter int CNT_W = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             wr,
   input  logic [CNT_W-1:0] wdata,
   input  logic             reload,
   output logic [CNT_W-1:0] staged,
   output logic [CNT_W-1:0] active
);

   logic [CNT_W-1:0] stage_q;
   logic [CNT_W-1:0] act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   stage_q <= '0;
      else if (wr)  stage_q <= wdata;
   end

   // A write in the reload cycle lands in staging and waits for the next wrap
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 act_q <= '0;
      else if (!run || reload)    act_q <= stage_q;
   end

   assign staged = stage_q;
   assign active = act_q;

endmodule

// File: rtl/pwm8_out_stage.sv
module pwm8_out_stage #(
   parameter int CNT_W = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             wrap,
   input  logic [CNT_W-1:0] cnt_next,
   input  logic [CNT_W-1:0] duty_active,
   input  logic [CNT_W-1:0] duty_incoming,
   output logic             pin
);

   logic pin_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               pin_q <= 1'b0;
      else if (!run)            pin_q <= 1'b0;
      else if (wrap)            pin_q <= (duty_incoming != '0);
      else if (tick && (cnt_next == duty_active))
                                pin_q <= 1'b0;
   end

   assign pin = pin_q;

endmodule

// File: rtl/pwm8_rollover.sv
module pwm8_rollover
   import pwm8_pkg::*;
#(
   parameter int CNT_W     = 8,
   parameter int DIV_W     = 8,
   parameter int DIV_STYLE = DIV_LINEAR
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             slow_mode,
   input  logic [DIV_W-1:0] slow_div,
   input  logic             duty_wr,
   input  logic [CNT_W-1:0] duty_wdata,
   output logic             pwm_out
);

   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt
         $error("pwm8_rollover: CNT_W must lie in 2..16");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("pwm8_rollover: DIV_W must be at least 1");
      end
      if (DIV_STYLE != DIV_LINEAR && DIV_STYLE != DIV_EXP) begin : g_bad_style
         $error("pwm8_rollover: unknown DIV_STYLE");
      end
      if (DIV_STYLE == DIV_EXP && DIV_W > 4) begin : g_bad_exp
         $error("pwm8_rollover: exponential divider needs DIV_W <= 4");
      end
   endgenerate

   step_mode_e       mode;
   logic             tick;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nx;
   logic             wrap;
   logic [CNT_W-1:0] duty_stg;
   logic [CNT_W-1:0] duty_act;

   assign mode = slow_mode ? STEP_SLOW : STEP_FAST;

   pwm8_tick_gen #(
      .DIV_W     (DIV_W),
      .DIV_STYLE (DIV_STYLE)
   ) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (en),
      .mode  (mode),
      .div   (slow_div),
      .tick  (tick)
   );

   pwm8_wrap_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (en),
      .tick     (tick),
      .cnt      (cnt_q),
      .cnt_next (cnt_nx),
      .wrap     (wrap)
   );

   pwm8_duty_bank #(
      .CNT_W (CNT_W)
   ) u_duty (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (en),
      .wr     (duty_wr),
      .wdata  (duty_wdata),
      .reload (wrap),
      .staged (duty_stg),
      .active (duty_act)
   );

   pwm8_out_stage #(
      .CNT_W (CNT_W)
   ) u_out (
      .clk           (clk),
      .rst_n         (rst_n),
      .run           (en),
      .tick          (tick),
      .wrap          (wrap),
      .cnt_next      (cnt_nx),
      .duty_active   (duty_act),
      .duty_incoming (duty_stg),
      .pin           (pwm_out)
   );

endmodule

// File: rtl/pwm8_rollover_chk.sv
module pwm8_rollover_chk #(
   parameter int CNT_W = 8
)(
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             slow_mode,
   input logic             pwm_out,
   input logic             tick,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] duty_act
);

   // R9: disabled means low output and counter at zero one edge later
   p_off_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!pwm_out && cnt == '0));

   // R4: a rising edge only ever follows the wrap to zero
   p_rise_at_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_out) |-> (cnt == '0));

   // R6: no rising edge while the loaded duty is zero
   p_zero_no_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_out) |-> (duty_act != '0));

   // R5: a falling edge while running lands on the compare point
   p_fall_on_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(pwm_out) && en && $past(en)) |-> (cnt == duty_act));

   // R8: active duty changes only at the wrap while running
   p_duty_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && cnt != '0) |-> $stable(duty_act));

   // R2: fast mode never issues steps on consecutive clocks
   p_fast_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !slow_mode && $past(en) && !$past(slow_mode) && $past(tick)) |-> !tick);

   // R2, R3: the counter moves by at most one per clock while running
   p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en)) |-> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1)));

endmodule

bind pwm8_rollover pwm8_rollover_chk #(
   .CNT_W (CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .en        (en),
   .slow_mode (slow_mode),
   .pwm_out   (pwm_out),
   .tick      (tick),
   .cnt       (cnt_q),
   .duty_act  (duty_act)
);

// File: tb/pwm8_rollover_bench.sv
module pwm8_rollover_bench;

   localparam int LIM = 8000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic       slow_mode = 1'b0;
   logic [7:0] slow_div = 8'd0;
   logic       duty_wr = 1'b0;
   logic [7:0] duty_wdata = 8'd0;
   logic       pwm_out;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pwm8_rollover u_pwm8_rollover (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en),
      .slow_mode  (slow_mode),
      .slow_div   (slow_div),
      .duty_wr    (duty_wr),
      .duty_wdata (duty_wdata),
      .pwm_out    (pwm_out)
   );

   task automatic check_eq(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic write_duty(input logic [7:0] v);
      duty_wdata = v;
      duty_wr = 1'b1;
      @(negedge clk);
      duty_wr = 1'b0;
   endtask

   // Waits for the next rising edge, then counts high and low samples
   task automatic measure(output int hi, output int per);
      int guard = 0;
      int lo = 0;
      hi = -1;
      per = -1;
      while (pwm_out && guard < LIM) begin @(negedge clk); guard++; end
      while (!pwm_out && guard < LIM) begin @(negedge clk); guard++; end
      if (guard >= LIM) return;
      hi = 0;
      while (pwm_out && hi < LIM) begin hi++; @(negedge clk); end
      while (!pwm_out && lo < LIM) begin lo++; @(negedge clk); end
      per = hi + lo;
   endtask

   task automatic t_reset;
      check_eq("R1 output low in reset", int'(pwm_out), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_eq("R1 output low after reset", int'(pwm_out), 0);
   endtask

   task automatic t_fast(input logic [7:0] d);
      int hi;
      int per;
      write_duty(d);
      measure(hi, per);
      measure(hi, per);
      check_eq($sformatf("R5 fast high time duty=%0d", d), hi, int'(d) * 2);
      check_eq($sformatf("R2 R4 fast period duty=%0d", d), per, 512);
   endtask

   task automatic t_zero;
      int highs = 0;
      write_duty(8'h00);
      repeat (600) @(negedge clk);
      for (int i = 0; i < 1100; i++) begin
         if (pwm_out) highs++;
         @(negedge clk);
      end
      check_eq("R6 duty zero stays low", highs, 0);
   endtask

   task automatic t_full;
      int hi;
      int per;
      write_duty(8'hFF);
      measure(hi, per);
      measure(hi, per);
      check_eq("R7 duty 0xFF high time", hi, 510);
      check_eq("R7 duty 0xFF period", per, 512);
   endtask

   task automatic t_slow;
      int hi;
      int per;
      write_duty(8'h20);
      slow_div = 8'd3;
      slow_mode = 1'b1;
      measure(hi, per);
      measure(hi, per);
      check_eq("R3 slow high time", hi, 32 * 8);
      check_eq("R3 slow period", per, 2048);
      slow_mode = 1'b0;
   endtask

   task automatic t_shadow;
      int hi = 0;
      int per;
      write_duty(8'h40);
      measure(hi, per);
      while (pwm_out) @(negedge clk);
      while (!pwm_out) @(negedge clk);
      // a rise was just seen: write mid-pulse, the current pulse keeps 0x40
      duty_wdata = 8'h10;
      duty_wr = 1'b1;
      hi = 0;
      while (pwm_out && hi < LIM) begin
         hi++;
         @(negedge clk);
         duty_wr = 1'b0;
      end
      check_eq("R8 pulse in progress keeps old duty", hi, 128);
      measure(hi, per);
      check_eq("R8 next pulse uses new duty", hi, 32);
   endtask

   task automatic t_disable;
      int lows = 0;
      int n = 0;
      int hi = 0;
      en = 1'b0;
      @(negedge clk);
      check_eq("R9 output low after disable", int'(pwm_out), 0);
      for (int i = 0; i < 600; i++) begin
         if (!pwm_out) lows++;
         @(negedge clk);
      end
      check_eq("R9 output held low while disabled", lows, 600);
      write_duty(8'h10);
      en = 1'b1;
      do begin
         @(negedge clk);
         n++;
      end while (!pwm_out && n < LIM);
      check_eq("R9 first rise after 256 steps", n, 512);
      while (pwm_out && hi < LIM) begin hi++; @(negedge clk); end
      check_eq("R10 first pulse uses duty written while disabled", hi, 32);
   endtask

   initial begin
      t_reset();
      en = 1'b1;
      t_fast(8'h40);
      t_fast(8'h01);
      t_fast(8'h80);
      t_zero();
      t_full();
      t_slow();
      t_shadow();
      t_disable();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule